// File: doc/BRIEF.md
# Descriptor Fetch Bus Sequencer

This block is the master-side sequencer that a network DMA engine uses to read one receive or transmit ring descriptor over a multiplexed address/data parallel bus with PCI-style signalling. On a start pulse it takes the descriptor base address, the direction (receive or transmit) and an 8-bit layout-style code. It asks for the bus and then runs one or two read transactions. Each transaction has an address phase, a turnaround and one or more data phases. The words it gets back are collected into a descriptor register.

The layout-style code sets how the descriptor is fetched. Codes 0 and 2 use two single-word transactions with an idle cycle between them; they differ in which word is read first. Codes 3, 4 and 5 use one burst, and its starting offset and length depend on the direction. Whatever the fetch order, the captured words come out in ascending address order. The same code also tells the engine whether the later descriptor write-back should be a burst. The arbiter, the target and parity are outside the block and reach it only through handshake inputs.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset, `req`, `frame`, `irdy`, `ad_oe` and `done` are low and `cbe` is 1111.
- R2: A transaction starts when `gnt` is high while `req` is high; the next cycle is the address phase. With `gnt` held high, the first address phase comes two cycles after the start pulse. The address phase lasts exactly one cycle with `frame` high, `ad_oe` high, `ad_out` = base + offset and `cbe` = 0110 (memory read). The cycle after it is a turnaround with `frame` high, `ad_oe` low, `irdy` low and `cbe` = 0000. Every data phase also carries `cbe` = 0000.
- R3: `devsel` is sampled at the end of each turnaround cycle. While it is low, the turnaround repeats and no data phase starts.
- R4: A data phase (`irdy` high) completes only in a cycle where `trdy` is also high. A wait state keeps the same word pending.
- R5: `frame` is low throughout the final data phase of each transaction and high during its earlier data phases.
- R6: Code 0 reads offset 00h and then 04h, and code 2 reads 04h and then 00h. In both cases each word is its own one-data-phase transaction, and exactly one idle cycle (`frame` and `irdy` low, `req` high) separates the two transactions.
- R7: For receive (`is_tx`=0), codes 3 and 4 make a single burst at offset 04h with 2 data phases, and code 5 makes one at offset 08h with 3 data phases.
- R8: For transmit (`is_tx`=1), codes 3, 4 and 5 make a single burst at offset 00h with 2, 3 and 4 data phases respectively.
- R9: Any code other than 0, 2, 3, 4 or 5 behaves exactly like code 0.
- R10: `done` is high for exactly one cycle, in the cycle after the last data phase completes. At that point `desc_cnt` holds the word count. Slot k of `desc_data` (bits k*32 upward) holds the word from the k-th lowest fetched offset, and unused slots read zero.
- R11: `wb_burst` follows the current inputs combinationally. It is 1 for codes 3, 4 and 5 and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start one descriptor fetch (taken only when idle) |
| is_tx | input | 1 | 1 = transmit descriptor, 0 = receive |
| sw_style | input | 8 | Descriptor layout-style code |
| base_addr | input | ADDR_W | Descriptor base address |
| gnt | input | 1 | Bus grant |
| devsel | input | 1 | Target claimed the access |
| trdy | input | 1 | Target ready |
| ad_in | input | DATA_W | Read data from the bus |
| req | output | 1 | Bus request |
| frame | output | 1 | Transaction active, low on final data phase |
| irdy | output | 1 | Initiator ready (data phases) |
| ad_oe | output | 1 | Address driven on the bus |
| ad_out | output | ADDR_W | Address during the address phase, zero otherwise |
| cbe | output | 4 | Command / byte-enable code |
| done | output | 1 | One-cycle completion pulse |
| desc_cnt | output | clog2(MAX_WORDS+1) | Number of captured words |
| desc_data | output | MAX_WORDS*DATA_W | Captured words, ascending offset order |
| wb_burst | output | 1 | Write-back for this code uses burst mode |

## Verification
`wb_burst` is combinational and is checked one time unit after the inputs change. Bus outputs are Moore decodes of the state register. The address phase therefore shows up two cycles after start, the turnaround one cycle after the address, and `done` exactly one cycle after the final accepted beat. The bench drives inputs and samples outputs on the falling edge, numbers every cycle from the start pulse, and compares the cycle in which each event is seen with these offsets. It also counts data phases, idle gaps and turnaround length per transaction, and checks the captured words and count during the `done` cycle.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

  localparam int PLAN_W = 3;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;
  localparam logic [3:0] BE_ALL_LANES = 4'b0000;
  localparam logic [3:0] CBE_PARKED   = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_TA,
    ST_DATA,
    ST_GAP,
    ST_DONE
  } dfs_state_e;

  // Fetch plan: offsets are in 32-bit word units relative to the base.
  typedef struct packed {
    logic              two_txn;
    logic              burst;
    logic [PLAN_W-1:0] beats;
    logic [PLAN_W-1:0] off0_w;
    logic [PLAN_W-1:0] off1_w;
    logic [PLAN_W-1:0] min_w;
    logic [PLAN_W-1:0] total;
  } fetch_plan_t;

endpackage

// File: rtl/dfs_style_decode.sv
module dfs_style_decode
  import dfs_pkg::*;
(
  input  logic [7:0]  sw_style,
  input  logic        is_tx,
  output fetch_plan_t plan
);

  always_comb begin
    // Default and code 0: two single reads, low word first.
    plan.two_txn = 1'b1;
    plan.burst   = 1'b0;
    plan.beats   = PLAN_W'(1);
    plan.off0_w  = PLAN_W'(0);
    plan.off1_w  = PLAN_W'(1);
    plan.min_w   = PLAN_W'(0);
    plan.total   = PLAN_W'(2);
    case (sw_style)
      8'd2: begin
        plan.off0_w = PLAN_W'(1);
        plan.off1_w = PLAN_W'(0);
      end
      8'd3, 8'd4, 8'd5: begin
        plan.two_txn = 1'b0;
        plan.burst   = 1'b1;
        plan.off1_w  = PLAN_W'(0);
        if (is_tx) begin
          plan.off0_w = PLAN_W'(0);
          plan.min_w  = PLAN_W'(0);
          plan.beats  = PLAN_W'(sw_style[2:0] - 3'd1);
        end else if (sw_style == 8'd5) begin
          plan.off0_w = PLAN_W'(2);
          plan.min_w  = PLAN_W'(2);
          plan.beats  = PLAN_W'(3);
        end else begin
          plan.off0_w = PLAN_W'(1);
          plan.min_w  = PLAN_W'(1);
          plan.beats  = PLAN_W'(2);
        end
        plan.total = plan.beats;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dfs_bus_fsm.sv
module dfs_bus_fsm
  import dfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fetch_plan_t       plan_in,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              gnt,
  input  logic              devsel,
  input  logic              trdy,
  output logic              req,
  output logic              frame,
  output logic              irdy,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic [3:0]        cbe,
  output logic              clear,
  output logic              beat_done,
  output logic [SLOT_W-1:0] beat_slot,
  output logic              done
);

  dfs_state_e        state_q, state_d;
  fetch_plan_t       plan_q;
  logic [ADDR_W-1:0] base_q;
  logic [PLAN_W-1:0] beat_cnt_q, beat_cnt_d;
  logic [PLAN_W-1:0] off_q, off_d;
  logic              txn_q, txn_d;
  logic              load_en, last_beat;

  assign load_en   = (state_q == ST_IDLE) && start;
  assign last_beat = (beat_cnt_q == plan_q.beats - PLAN_W'(1));

  // Next-state process
  always_comb begin
    state_d    = state_q;
    beat_cnt_d = beat_cnt_q;
    off_d      = off_q;
    txn_d      = txn_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_REQ;
        off_d   = plan_in.off0_w;
        txn_d   = 1'b0;
      end
      ST_REQ:  if (gnt) state_d = ST_ADDR;
      ST_ADDR: begin
        state_d    = ST_TA;
        beat_cnt_d = '0;
      end
      ST_TA:   if (devsel) state_d = ST_DATA;
      ST_DATA: if (trdy) begin
        beat_cnt_d = beat_cnt_q + PLAN_W'(1);
        off_d      = off_q + PLAN_W'(1);
        if (last_beat) begin
          if (plan_q.two_txn && !txn_q) begin
            state_d = ST_GAP;
            txn_d   = 1'b1;
            off_d   = plan_q.off1_w;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_GAP:  state_d = gnt ? ST_ADDR : ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      plan_q     <= '0;
      base_q     <= '0;
      beat_cnt_q <= '0;
      off_q      <= '0;
      txn_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_cnt_q <= beat_cnt_d;
      off_q      <= off_d;
      txn_q      <= txn_d;
      if (load_en) begin
        plan_q <= plan_in;
        base_q <= base_addr;
      end
    end
  end

  // Moore output decode
  always_comb begin
    req       = (state_q == ST_REQ) || (state_q == ST_GAP);
    irdy      = (state_q == ST_DATA);
    ad_oe     = (state_q == ST_ADDR);
    frame     = (state_q == ST_ADDR) || (state_q == ST_TA) ||
                ((state_q == ST_DATA) && !last_beat);
    ad_out    = ad_oe ? (base_q + ADDR_W'({off_q, 2'b00})) : '0;
    if (state_q == ST_ADDR)
      cbe = CMD_MEM_READ;
    else if ((state_q == ST_TA) || (state_q == ST_DATA))
      cbe = BE_ALL_LANES;
    else
      cbe = CBE_PARKED;
    clear     = load_en;
    beat_done = irdy && trdy;
    beat_slot = SLOT_W'(off_q - plan_q.min_w);
    done      = (state_q == ST_DONE);
  end

  // Checker-only word counter
  logic [PLAN_W-1:0] words_got_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        words_got_q <= '0;
    else if (load_en)  words_got_q <= '0;
    else if (beat_done) words_got_q <= words_got_q + PLAN_W'(1);
  end

  p_addr_then_ta_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> (!ad_oe && frame && !irdy && cbe == BE_ALL_LANES));
  p_addr_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (cbe == CMD_MEM_READ && frame));
  p_ta_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !ad_oe && !irdy && !devsel) |=> (frame && !ad_oe && !irdy));
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && !trdy) |=> (irdy && $stable(beat_cnt_q) && $stable(frame)));
  p_final_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && trdy && !frame) |=> !irdy);
  p_nonfinal_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy && trdy && frame) |=> irdy);
  p_gap_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (plan_q.two_txn && !plan_q.burst));
  p_done_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (words_got_q == plan_q.total));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/dfs_capture.sv
module dfs_capture #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4,
  parameter int SLOT_W    = 2,
  parameter int CNT_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [CNT_W-1:0]            cnt_in,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [MAX_WORDS*DATA_W-1:0] words,
  output logic [CNT_W-1:0]            cnt
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= cnt_in;
  end
  assign cnt = cnt_q;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    logic [DATA_W-1:0] word_q, word_d;
    logic              word_en;

    assign word_en = clear || (wr_en && (wr_slot == SLOT_W'(g)));
    assign word_d  = clear ? '0 : wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end
    assign words[g*DATA_W +: DATA_W] = word_q;
  end

  p_slot_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < MAX_WORDS));
  p_no_write_on_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !wr_en);

endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import dfs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             is_tx,
  input  logic [7:0]                       sw_style,
  input  logic [ADDR_W-1:0]                base_addr,
  input  logic                             gnt,
  input  logic                             devsel,
  input  logic                             trdy,
  input  logic [DATA_W-1:0]                ad_in,
  output logic                             req,
  output logic                             frame,
  output logic                             irdy,
  output logic                             ad_oe,
  output logic [ADDR_W-1:0]                ad_out,
  output logic [3:0]                       cbe,
  output logic                             done,
  output logic [$clog2(MAX_WORDS+1)-1:0]   desc_cnt,
  output logic [MAX_WORDS*DATA_W-1:0]      desc_data,
  output logic                             wb_burst
);

  localparam int SLOT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int CNT_W  = $clog2(MAX_WORDS+1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fetch_plan_t       plan;
  logic              clear, beat_done;
  logic [SLOT_W-1:0] beat_slot;

  dfs_style_decode u_decode (
    .sw_style (sw_style),
    .is_tx    (is_tx),
    .plan     (plan)
  );

  assign wb_burst = plan.burst;

  dfs_bus_fsm #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .plan_in   (plan),
    .base_addr (base_addr),
    .gnt       (gnt),
    .devsel    (devsel),
    .trdy      (trdy),
    .req       (req),
    .frame     (frame),
    .irdy      (irdy),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .cbe       (cbe),
    .clear     (clear),
    .beat_done (beat_done),
    .beat_slot (beat_slot),
    .done      (done)
  );

  dfs_capture #(
    .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (clear),
    .cnt_in  (CNT_W'(plan.total)),
    .wr_en   (beat_done),
    .wr_slot (beat_slot),
    .wr_data (ad_in),
    .words   (desc_data),
    .cnt     (desc_cnt)
  );

  p_burst_code_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sw_style == 8'd3 || sw_style == 8'd4 || sw_style == 8'd5) |-> wb_burst);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_int_n |=> (!req && !frame && !irdy && !done));

endmodule

// File: tb/desc_fetch_seq_tb.sv
module desc_fetch_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 4;

  logic        clk, rst_n, start, is_tx, gnt, devsel, trdy;
  logic [7:0]  sw_style;
  logic [31:0] base_addr, ad_in, ad_out;
  logic        req, frame, irdy, ad_oe, done, wb_burst;
  logic [3:0]  cbe;
  logic [2:0]  desc_cnt;
  logic [MAXW*32-1:0] desc_data;

  int total_checks = 0;
  int bad_checks = 0;
  bit finished = 0;

  desc_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_tx(is_tx), .sw_style(sw_style),
    .base_addr(base_addr), .gnt(gnt), .devsel(devsel), .trdy(trdy), .ad_in(ad_in),
    .req(req), .frame(frame), .irdy(irdy), .ad_oe(ad_oe), .ad_out(ad_out),
    .cbe(cbe), .done(done), .desc_cnt(desc_cnt), .desc_data(desc_data),
    .wb_burst(wb_burst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input longint act, input longint exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return 32'hA500_0000 ^ a;
  endfunction

  // Generic runner: drives one fetch and acts as the target.
  task automatic run_case(input string tag, input logic [7:0] code, input bit tx,
                          input logic [31:0] base, input bit waits, input int dsel_delay,
                          input int exp_nt, input int off0, input int off1,
                          input int exp_beats, input int min_off, input int exp_total,
                          input bit exp_wb);
    int nt = 0, cyc = 0, ta_cnt = 0, dcyc = 0, frame_err = 0, gap = -1;
    int first_addr_cyc = -1, last_beat_cyc = -1, done_cnt = 0, done_cyc = -1;
    int ta_first = 0, req_at1 = 0, ta_sig_ok = 1;
    int beats [2];
    logic [31:0] taddr [2];
    logic [31:0] cur;
    bit seen_done = 0;
    int post = 0;
    beats[0] = 0; beats[1] = 0; taddr[0] = '0; taddr[1] = '0; cur = '0;

    @(negedge clk);
    sw_style = code; is_tx = tx; base_addr = base; start = 1'b1;
    #1;
    chk(wb_burst == exp_wb, "R11", {tag, " wb_burst"}, wb_burst, exp_wb);
    while (post < 3 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      trdy = 1'b0;
      devsel = 1'b1;
      if (cyc == 1) req_at1 = req;
      if (ad_oe && frame) begin
        if (cbe != 4'b0110) ta_sig_ok = 0;
        if (nt < 2) taddr[nt] = ad_out;
        if (nt == 1) gap = cyc - last_beat_cyc - 1;
        if (nt == 0) first_addr_cyc = cyc;
        nt++;
        cur = ad_out;
        ta_cnt = 0;
      end else if (frame && !irdy) begin
        ta_cnt++;
        if (ta_cnt == 1 && (ad_oe || cbe != 4'b0000)) ta_sig_ok = 0;
        if (nt == 1) ta_first = ta_cnt;
        devsel = (ta_cnt > dsel_delay);
      end
      if (irdy) begin
        dcyc++;
        if (cbe != 4'b0000) ta_sig_ok = 0;
        trdy = waits ? (dcyc % 2 == 0) : 1'b1;
        ad_in = word_at(cur);
        if (trdy && nt >= 1 && nt <= 2) begin
          beats[nt-1]++;
          if (frame == (beats[nt-1] == exp_beats)) frame_err++;
          cur = cur + 32'd4;
          last_beat_cyc = cyc;
        end
      end
      if (done) begin
        done_cnt++;
        if (!seen_done) begin
          done_cyc = cyc;
          chk(desc_cnt == 3'(exp_total), "R10", {tag, " desc_cnt"}, desc_cnt, exp_total);
          for (int k = 0; k < MAXW; k++) begin
            logic [31:0] e;
            e = (k < exp_total) ? word_at(base + 32'(4*(min_off + k))) : 32'h0;
            chk(desc_data[k*32 +: 32] == e, "R10", {tag, " slot word"},
                desc_data[k*32 +: 32], e);
          end
        end
        seen_done = 1;
      end
      if (seen_done) post++;
    end
    trdy = 1'b0;
    chk(req_at1 == 1, "R2", {tag, " req after start"}, req_at1, 1);
    chk(first_addr_cyc == 2, "R2", {tag, " first address cycle"}, first_addr_cyc, 2);
    chk(ta_sig_ok == 1, "R2", {tag, " address/turnaround codes"}, ta_sig_ok, 1);
    chk(ta_first == dsel_delay + 1, "R3", {tag, " turnaround length"}, ta_first, dsel_delay + 1);
    chk(nt == exp_nt, "R6/R7/R8/R9", {tag, " transaction count"}, nt, exp_nt);
    chk(taddr[0] == base + 32'(4*off0), "R6/R7/R8/R9", {tag, " first address"},
        taddr[0], base + 32'(4*off0));
    chk(beats[0] == exp_beats, "R4/R7/R8", {tag, " beats txn0"}, beats[0], exp_beats);
    if (exp_nt == 2) begin
      chk(taddr[1] == base + 32'(4*off1), "R6", {tag, " second address"},
          taddr[1], base + 32'(4*off1));
      chk(beats[1] == exp_beats, "R6", {tag, " beats txn1"}, beats[1], exp_beats);
      chk(gap == 1, "R6", {tag, " idle gap"}, gap, 1);
    end
    chk(frame_err == 0, "R5", {tag, " frame on final phase"}, frame_err, 0);
    chk(done_cnt == 1, "R10", {tag, " done width"}, done_cnt, 1);
    chk(done_cyc == last_beat_cyc + 1, "R10", {tag, " done timing"}, done_cyc, last_beat_cyc + 1);
  endtask

  task automatic t_reset_r1();
    chk(!req && !frame && !irdy && !ad_oe && !done, "R1", "idle controls",
        {req, frame, irdy, ad_oe, done}, 0);
    chk(cbe == 4'b1111, "R1", "cbe parked", cbe, 4'hF);
  endtask

  task automatic t_code0_rx_r6();
    run_case("code0 rx", 8'd0, 1'b0, 32'h0000_1000, 0, 0, 2, 0, 1, 1, 0, 2, 0);
  endtask
  task automatic t_code2_tx_r6();
    run_case("code2 tx", 8'd2, 1'b1, 32'h0000_2040, 0, 0, 2, 1, 0, 1, 0, 2, 0);
  endtask
  task automatic t_rx3_r7();
    run_case("rx3", 8'd3, 1'b0, 32'h0000_3000, 0, 0, 1, 1, 0, 2, 1, 2, 1);
  endtask
  task automatic t_rx4_waits_r4();
    run_case("rx4 waits R4", 8'd4, 1'b0, 32'h0000_3100, 1, 0, 1, 1, 0, 2, 1, 2, 1);
  endtask
  task automatic t_tx5_waits_r8();
    run_case("tx5 waits", 8'd5, 1'b1, 32'h0000_4000, 1, 0, 1, 0, 0, 4, 0, 4, 1);
  endtask
  task automatic t_rx5_r7();
    run_case("rx5", 8'd5, 1'b0, 32'h0000_5000, 0, 0, 1, 2, 0, 3, 2, 3, 1);
  endtask
  task automatic t_tx3_r8();
    run_case("tx3", 8'd3, 1'b1, 32'h0000_6000, 0, 0, 1, 0, 0, 2, 0, 2, 1);
  endtask
  task automatic t_tx4_devsel_r3();
    run_case("tx4 devsel R3", 8'd4, 1'b1, 32'h0000_7000, 0, 2, 1, 0, 0, 3, 0, 3, 1);
  endtask
  task automatic t_unknown_r9();
    run_case("code7 tx R9", 8'd7, 1'b1, 32'h0000_8000, 0, 0, 2, 0, 1, 1, 0, 2, 0);
    run_case("code1 rx R9", 8'd1, 1'b0, 32'h0000_9000, 0, 0, 2, 0, 1, 1, 0, 2, 0);
    run_case("codeFF rx R9", 8'hFF, 1'b0, 32'h0000_A000, 1, 1, 2, 0, 1, 1, 0, 2, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_tx = 1'b0; sw_style = 8'd0;
    base_addr = '0; gnt = 1'b1; devsel = 1'b1; trdy = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_code0_rx_r6();
    t_code2_tx_r6();
    t_rx3_r7();
    t_rx4_waits_r4();
    t_tx5_waits_r8();
    t_rx5_r7();
    t_tx3_r8();
    t_tx4_devsel_r3();
    t_unknown_r9();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

endmodule